// File: doc/BRIEF.md
# Configurable Hamming Error-Correcting Decoder

This block takes a received message word and the check word that travelled with it. It recomputes the Hamming check bits to form a syndrome. When the code carries an extra overall parity bit, it also forms a whole-word parity mismatch. One register stage later it presents the message, the valid strobe and two flags. The message is repaired when that is allowed. One flag marks a word that was repaired. The other marks a word with an error that could not be repaired.

Two compile-time switches pick the mode. `OVERALL_PAR` adds or drops the extra parity bit. `FIX_EN` turns correction on or off. Without the extra bit, the block either flags one- and two-bit errors or corrects single errors. With the extra bit, it either flags one- to three-bit errors or corrects single errors and flags double errors. Messages shorter than the code's natural data capacity are zero-extended internally, so the data ports can be narrower than the code.

The data path is a simple stream with no back-pressure. `en_i` acts as the input valid and `valid_o` as the output valid. Every enabled word produces exactly one result on the following cycle. There is no ready signal, so the sink must accept every cycle in which `valid_o` is high.

Top module: `ham_decoder`

## Requirements
- R1: The Hamming check count P is the smallest value with 2^P >= MSG_W + P + 1. Message bit k sits at the k-th position, counting upward from 1, that is not a power of two. For MSG_W = 5 these positions are 3, 5, 6, 7 and 9. `par_i[j]` is the check bit at position 2^j and covers every position whose index has bit j set. When present, `par_i[P]` is the XOR of all message and check bits. Code positions up to 2^P-1 that carry no message bit read as zero.
- R2: A word presented with `en_i` high yields `valid_o` high on the next rising edge, with that word's result on `data_o`, `fixed_o` and `fail_o`.
- R3: After a rising edge with `en_i` low, `valid_o`, `data_o`, `fixed_o` and `fail_o` are all zero.
- R4: Asserting `rst_i` high clears all outputs at once, without waiting for a clock edge.
- R5: A word with no bit errors comes out unchanged, with both flags low, in every mode.
- R6: With no overall bit and correction off, any one- or two-bit error raises `fail_o`. The received data is passed unchanged and `fixed_o` stays low.
- R7: With no overall bit and correction on, a single error in any received bit is repaired. `data_o` shows the sent message and `fixed_o` is high.
- R8: With the overall bit and correction off, any one-, two- or three-bit error raises `fail_o`. The received data is passed unchanged and `fixed_o` stays low.
- R9: With the overall bit and correction on, a single error in any received bit, including the overall bit, is repaired with `fixed_o` high. A two-bit error raises `fail_o`, keeps `fixed_o` low and passes the received data unchanged.
- R10: When correction is on and a single-error syndrome names a zero-extended message position, `fail_o` is raised, `fixed_o` stays low and the data passes unchanged.
- R11: `fixed_o` and `fail_o` are never high together. A word without `fixed_o` carries the received data unchanged. A word with `fixed_o` differs from the received data in at most one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| en_i | input | 1 | Input valid / synchronous enable |
| data_i | input | MSG_W | Received message |
| par_i | input | P + OVERALL_PAR | Received check bits, overall bit on top |
| data_o | output | MSG_W | Message, repaired when allowed |
| valid_o | output | 1 | Result valid |
| fixed_o | output | 1 | A single error was repaired |
| fail_o | output | 1 | Error detected that was not repaired |

## Verification
The assertions assume that `en_i`, `data_i` and `par_i` hold known two-state values in every cycle once reset is released. They also assume that reset is released away from a rising edge, because every property relates one cycle's outputs to the inputs of the cycle before. The stimulus meets these assumptions by driving all inputs from time zero and changing them only on falling edges. It releases reset on a falling edge and sweeps every message value against every error mask on a five-bit configuration of all four modes.

// File: rtl/ham_pkg.sv
package ham_pkg;

  // Smallest check count whose code holds k message bits.
  function automatic int hp_count(input int k);
    int p;
    p = 1;
    while ((1 << p) < k + p + 1) p = p + 1;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Message index held at a non-power-of-two code position.
  function automatic int data_idx(input int pos);
    return pos - $clog2(pos + 1) - 1;
  endfunction

  // Code position of message bit k.
  function automatic int data_pos(input int k);
    int pos;
    int cnt;
    pos = 0;
    cnt = -1;
    while (cnt < k) begin
      pos = pos + 1;
      if (!is_pow2(pos)) cnt = cnt + 1;
    end
    return pos;
  endfunction

endpackage

// File: rtl/ham_syndrome.sv
module ham_syndrome
  import ham_pkg::*;
#(
  parameter int MSG_W       = 5,
  parameter int HP          = 4,
  parameter int OVERALL_PAR = 1,
  localparam int PW         = HP + OVERALL_PAR,
  localparam int NPOS       = (1 << HP) - 1
) (
  input  logic [MSG_W-1:0] data_i,
  input  logic [PW-1:0]    par_i,
  output logic [HP-1:0]    syn_o,
  output logic             mism_o
);

  logic [NPOS:1] cw;

  // Lay the received bits onto the full-length code.
  for (genvar p = 1; p <= NPOS; p++) begin : g_pos
    if (is_pow2(p)) begin : g_chk
      assign cw[p] = par_i[$clog2(p)];
    end else if (data_idx(p) < MSG_W) begin : g_live
      assign cw[p] = data_i[data_idx(p)];
    end else begin : g_pad
      assign cw[p] = 1'b0;
    end
  end

  // Syndrome is the XOR of the indices of all set positions.
  always_comb begin
    syn_o = '0;
    for (int p = 1; p <= NPOS; p++) begin
      if (cw[p]) syn_o = syn_o ^ HP'(p);
    end
  end

  if (OVERALL_PAR != 0) begin : g_ovr
    assign mism_o = ^{data_i, par_i};
  end else begin : g_noovr
    assign mism_o = 1'b0;
  end

endmodule

// File: rtl/ham_fix.sv
module ham_fix
  import ham_pkg::*;
#(
  parameter int MSG_W       = 5,
  parameter int HP          = 4,
  parameter int OVERALL_PAR = 1,
  parameter int FIX_EN      = 1
) (
  input  logic [MSG_W-1:0] data_i,
  input  logic [HP-1:0]    syn_i,
  input  logic             mism_i,
  output logic [MSG_W-1:0] data_o,
  output logic             fixed_o,
  output logic             fail_o
);

  logic syn_nz;
  assign syn_nz = |syn_i;

  if (FIX_EN == 0) begin : g_flag
    // Detection only: any nonzero syndrome or parity mismatch is reported.
    assign data_o  = data_i;
    assign fixed_o = 1'b0;
    assign fail_o  = syn_nz | mism_i;
  end else begin : g_fix
    logic [MSG_W-1:0] hit;
    logic             syn_p2;
    logic             pad_hit;
    logic             single;
    logic             repair;

    for (genvar k = 0; k < MSG_W; k++) begin : g_hit
      assign hit[k] = (syn_i == HP'(data_pos(k)));
    end

    assign syn_p2  = syn_nz && ((syn_i & (syn_i - HP'(1))) == '0);
    assign pad_hit = syn_nz && !syn_p2 && !(|hit);
    // Without an overall bit every nonzero syndrome is taken as one error.
    assign single  = syn_nz && ((OVERALL_PAR == 0) || mism_i);
    assign repair  = single && !pad_hit;

    assign data_o  = repair ? (data_i ^ hit) : data_i;
    assign fixed_o = repair || (!syn_nz && mism_i);
    assign fail_o  = (single && pad_hit) || (syn_nz && !single);
  end

endmodule

// File: rtl/ham_outreg.sv
module ham_outreg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] data_i,
  input  logic         fixed_i,
  input  logic         fail_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         fixed_o,
  output logic         fail_o
);

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      fixed_o <= 1'b0;
      fail_o  <= 1'b0;
    end else if (en_i) begin
      data_o  <= data_i;
      valid_o <= 1'b1;
      fixed_o <= fixed_i;
      fail_o  <= fail_i;
    end else begin
      data_o  <= '0;
      valid_o <= 1'b0;
      fixed_o <= 1'b0;
      fail_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/ham_decoder.sv
module ham_decoder
  import ham_pkg::*;
#(
  parameter int MSG_W       = 5,
  parameter int OVERALL_PAR = 1,
  parameter int FIX_EN      = 1,
  localparam int HP         = hp_count(MSG_W),
  localparam int PW         = HP + OVERALL_PAR
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [MSG_W-1:0] data_i,
  input  logic [PW-1:0]    par_i,
  output logic [MSG_W-1:0] data_o,
  output logic             valid_o,
  output logic             fixed_o,
  output logic             fail_o
);

  logic [HP-1:0]    syn;
  logic             mism;
  logic [MSG_W-1:0] cdata;
  logic             cfixed;
  logic             cfail;

  ham_syndrome #(
    .MSG_W(MSG_W), .HP(HP), .OVERALL_PAR(OVERALL_PAR)
  ) u_syn (
    .data_i(data_i), .par_i(par_i), .syn_o(syn), .mism_o(mism)
  );

  ham_fix #(
    .MSG_W(MSG_W), .HP(HP), .OVERALL_PAR(OVERALL_PAR), .FIX_EN(FIX_EN)
  ) u_fix (
    .data_i(data_i), .syn_i(syn), .mism_i(mism),
    .data_o(cdata), .fixed_o(cfixed), .fail_o(cfail)
  );

  ham_outreg #(.W(MSG_W)) u_reg (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
    .data_i(cdata), .fixed_i(cfixed), .fail_i(cfail),
    .data_o(data_o), .valid_o(valid_o), .fixed_o(fixed_o), .fail_o(fail_o)
  );

endmodule

// File: rtl/ham_decoder_chk.sv
module ham_decoder_chk #(
  parameter int MSG_W  = 5,
  parameter int FIX_EN = 1
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic [MSG_W-1:0] data_i,
  input logic [MSG_W-1:0] data_o,
  input logic             valid_o,
  input logic             fixed_o,
  input logic             fail_o
);

  // R2
  a_r2_valid_follows_en: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> valid_o);

  // R3
  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!valid_o && data_o == '0 && !fixed_o && !fail_o));

  // R11
  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    !(fixed_o && fail_o));

  a_r11_unfixed_passes: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (fixed_o || data_o == $past(data_i)));

  a_r11_one_bit_repair: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (!fixed_o || $countones(data_o ^ $past(data_i)) <= 1));

  if (FIX_EN == 0) begin : g_det
    // R6 / R8: detection modes never repair
    a_r8_never_fixed: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> !fixed_o);
  end

endmodule

bind ham_decoder ham_decoder_chk #(.MSG_W(MSG_W), .FIX_EN(FIX_EN)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .data_i(data_i),
  .data_o(data_o), .valid_o(valid_o), .fixed_o(fixed_o), .fail_o(fail_o)
);

// File: tb/ham_decoder_bench.sv
`timescale 1ns/1ps
module ham_decoder_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [4:0] din = '0;
  logic [3:0] p4  = '0;
  logic [4:0] p5  = '0;

  logic [4:0] q_dd, q_sc, q_td, q_sd;
  logic       v_dd, v_sc, v_td, v_sd;
  logic       f_dd, f_sc, f_td, f_sd;
  logic       x_dd, x_sc, x_td, x_sd;

  int n_checks = 0;
  int n_err    = 0;

  always #2.5 clk = ~clk;

  // detect, no overall bit
  ham_decoder #(.MSG_W(5), .OVERALL_PAR(0), .FIX_EN(0)) u_ham_decoder_dd (
    .clk_i(clk), .rst_i(rst), .en_i(en), .data_i(din), .par_i(p4),
    .data_o(q_dd), .valid_o(v_dd), .fixed_o(f_dd), .fail_o(x_dd));
  // correct, no overall bit
  ham_decoder #(.MSG_W(5), .OVERALL_PAR(0), .FIX_EN(1)) u_ham_decoder_sc (
    .clk_i(clk), .rst_i(rst), .en_i(en), .data_i(din), .par_i(p4),
    .data_o(q_sc), .valid_o(v_sc), .fixed_o(f_sc), .fail_o(x_sc));
  // detect, overall bit
  ham_decoder #(.MSG_W(5), .OVERALL_PAR(1), .FIX_EN(0)) u_ham_decoder_td (
    .clk_i(clk), .rst_i(rst), .en_i(en), .data_i(din), .par_i(p5),
    .data_o(q_td), .valid_o(v_td), .fixed_o(f_td), .fail_o(x_td));
  // correct, overall bit
  ham_decoder #(.MSG_W(5), .OVERALL_PAR(1), .FIX_EN(1)) u_ham_decoder (
    .clk_i(clk), .rst_i(rst), .en_i(en), .data_i(din), .par_i(p5),
    .data_o(q_sd), .valid_o(v_sd), .fixed_o(f_sd), .fail_o(x_sd));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  // R1: check bits for a 5-bit message on a 15-position code
  function automatic logic [3:0] enc_hp(input logic [4:0] d);
    logic [3:0] hp;
    int k;
    hp = '0;
    k = 0;
    for (int pos = 1; pos <= 15; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (k < 5 && d[k]) hp = hp ^ 4'(pos);
        k++;
      end
    end
    return hp;
  endfunction

  task automatic drive(input logic [4:0] d, input logic [9:0] m);
    logic [3:0] hp;
    hp  = enc_hp(d);
    din = d ^ m[4:0];
    p4  = hp ^ m[8:5];
    p5  = {(^d) ^ (^hp), hp} ^ m[9:5];
  endtask

  task automatic sweep_one(input logic [4:0] d, input logic [9:0] m);
    logic [4:0] rx;
    int wp, we;
    rx = d ^ m[4:0];
    wp = $countones(m[8:0]);
    we = $countones(m);
    en = 1'b1;
    drive(d, m);
    @(negedge clk);
    // R2
    check(v_dd && v_sc && v_td && v_sd, "R2 valid", {v_dd, v_sc, v_td, v_sd}, 4'hf);
    // R6 detect, no overall bit
    check(q_dd == rx && !f_dd, "R6 data", q_dd, rx);
    if (wp == 0) check(!x_dd, "R5 clean dd", x_dd, 0);
    else if (wp <= 2) check(x_dd, "R6 fail", x_dd, 1);
    // R7 correct, no overall bit
    if (wp == 0) check(q_sc == d && !f_sc && !x_sc, "R5 clean sc", {f_sc, x_sc, q_sc}, d);
    else if (wp == 1) check(q_sc == d && f_sc && !x_sc, "R7 repair", {f_sc, x_sc, q_sc}, {2'b10, d});
    else begin
      check(!(f_sc && x_sc), "R11 sc flags", {f_sc, x_sc}, 0);
      if (f_sc) check($countones(q_sc ^ rx) <= 1, "R11 sc one bit", q_sc, rx);
      else check(q_sc == rx, "R11 sc pass", q_sc, rx);
    end
    // R8 detect, overall bit
    check(q_td == rx && !f_td, "R8 data", q_td, rx);
    if (we == 0) check(!x_td, "R5 clean td", x_td, 0);
    else if (we <= 3) check(x_td, "R8 fail", x_td, 1);
    // R9 correct, overall bit
    if (we == 0) check(q_sd == d && !f_sd && !x_sd, "R5 clean sd", {f_sd, x_sd, q_sd}, d);
    else if (we == 1) check(q_sd == d && f_sd && !x_sd, "R9 repair", {f_sd, x_sd, q_sd}, {2'b10, d});
    else if (we == 2) check(q_sd == rx && !f_sd && x_sd, "R9 double", {f_sd, x_sd, q_sd}, {2'b01, rx});
    else begin
      check(!(f_sd && x_sd), "R11 sd flags", {f_sd, x_sd}, 0);
      if (f_sd) check($countones(q_sd ^ rx) <= 1, "R11 sd one bit", q_sd, rx);
      else check(q_sd == rx, "R11 sd pass", q_sd, rx);
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    // R4: reset held with inputs active
    en = 1'b1;
    drive(5'h15, 10'h003);
    repeat (3) @(negedge clk);
    check(!v_sd && q_sd == 0 && !f_sd && !x_sd, "R4 reset state", {v_sd, f_sd, x_sd, q_sd}, 0);
    check(!v_dd && !v_sc && !v_td, "R4 reset valid", {v_dd, v_sc, v_td}, 0);
    en = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    // R3: idle after reset
    check(!v_sd && q_sd == 0, "R3 idle", {v_sd, q_sd}, 0);

    for (int d = 0; d < 32; d++) begin
      for (int m = 0; m < 1024; m++) begin
        sweep_one(5'(d), 10'(m));
      end
    end

    // R10: syndrome 10 names a zero-extended position (two check-bit flips)
    en = 1'b1;
    din = 5'h00;
    p4 = 4'b1010;
    @(negedge clk);
    check(x_sc && !f_sc && q_sc == 0, "R10 pad syndrome", {f_sc, x_sc, q_sc}, {2'b01, 5'h00});

    // R3: enable low with an erroneous word
    en = 1'b0;
    drive(5'h0b, 10'h001);
    @(negedge clk);
    check(!v_sd && q_sd == 0 && !f_sd && !x_sd, "R3 en low sd", {v_sd, f_sd, x_sd, q_sd}, 0);
    check(!v_dd && q_dd == 0 && !x_dd, "R3 en low dd", {v_dd, x_dd, q_dd}, 0);

    // R4: asynchronous clear mid-cycle
    en = 1'b1;
    drive(5'h1f, 10'h000);
    @(negedge clk);
    check(v_sd && q_sd == 5'h1f, "R2 before async", {v_sd, q_sd}, {1'b1, 5'h1f});
    rst = 1'b1;
    #1;
    check(!v_sd && q_sd == 0 && !v_td && q_td == 0, "R4 async clear", {v_sd, q_sd}, 0);
    @(negedge clk);
    rst = 1'b0;
    en = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule